// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block turns single-byte host requests into chip-select, output-enable and write-enable waveforms for an 8-bit asynchronous memory or NAND flash device. A 32-bit timing word sets the cycle counts. Reads and writes each have their own setup, strobe and hold counts, and a shared turnaround count sets the gap inserted when the transfer direction changes. The timing word is taken in when a request is accepted. A change to the word after that point does not affect the access in progress.

The host offers a request with `req_valid`. The block accepts it in any cycle where `req_ready` is high. It answers with a one-cycle `acc_done` pulse, and for a read the captured byte is on `rd_data` at that point. When NAND mode is on, a write also raises the command-latch and/or address-latch line, as selected by two fixed bits of the request address. The device ready/busy line passes through a two-stage synchronizer to bit 0 of a status byte.

Top module: `amem_strobe_ctrl`

## Requirements
- R1: While reset is low and after it is released: `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1; `mem_cle`, `mem_ale`, `mem_dout_en` and `acc_done` are 0; `req_ready` is 1. This also applies when reset cuts an access short.
- R2: Timing word fields: write setup [29:26], write strobe [25:20], write hold [19:17], read setup [16:13], read strobe [12:7], read hold [6:4], turnaround [3:2]. Each phase lasts its field value plus one cycle. `mem_cs_n` is low for exactly setup+strobe+hold+3 consecutive cycles, using the fields for the access direction.
- R3: For a read, `mem_oe_n` is low for exactly read-strobe+1 cycles and `mem_we_n` stays high. `rd_data` holds the value `mem_din` had in the last strobe cycle. It is valid from the `acc_done` cycle onward.
- R4: For a write, `mem_we_n` is low for exactly write-strobe+1 cycles and `mem_oe_n` stays high. `mem_dout_en` is 1 and `mem_dout` equals the accepted byte for the whole chip-select window. `mem_addr` equals the accepted address during any access.
- R5: `acc_done` is high for exactly one cycle: the cycle after the last hold cycle. `req_ready` is high only when no access or turnaround is in progress.
- R6: If an accepted access has the opposite direction to the previous one, `turnaround+1` cycles with `mem_cs_n` high come before setup. There is no gap for the same direction, or for the first access after reset.
- R7: `nand_mode`=1 with a write sets `mem_cle` to address bit 4 and `mem_ale` to address bit 3, held for the whole chip-select window. Both lines are 0 on reads, outside the window, and whenever `nand_mode` was 0 at acceptance.
- R8: Bits [31:30] and [1:0] of the timing word have no effect on timing. Changes to `cfg_word`, `req_addr`, `req_wdata` or `nand_mode` after acceptance do not change the access in progress.
- R9: `stat_o[0]` follows `mem_rdy` two clock edges later, and `stat_o[7:1]` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 32 | Packed timing word |
| nand_mode | input | 1 | Enables command/address latch outputs |
| req_valid | input | 1 | Host request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write byte |
| req_ready | output | 1 | Block can accept a request |
| acc_done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read byte |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_cle | output | 1 | Command latch enable |
| mem_ale | output | 1 | Address latch enable |
| mem_addr | output | ADDR_W | Device address |
| mem_dout | output | DATA_W | Write data to device |
| mem_dout_en | output | 1 | Write data drive enable |
| mem_din | input | DATA_W | Read data from device |
| mem_rdy | input | 1 | Device ready/busy line |
| stat_o | output | 8 | Status byte, bit 0 = synchronized ready |

## Verification
A request accepted at clock edge k raises `acc_done` after edge k+N, where N = gap + setup + strobe + hold + 3 and the gap is turnaround+1 or 0. `rd_data` changes at the edge that closes the last strobe cycle, and `stat_o[0]` changes two edges after `mem_rdy`. The bench drives inputs and samples outputs at falling edges, one sample per cycle. It counts the chip-select-low, strobe-low and gap cycles until the sample that shows `acc_done`, then compares each count with the value computed from the vector's fields. During the read strobe it drives `mem_din` with the expected byte and at all other times with its complement. A capture one cycle early or late therefore shows up as a wrong value.

// File: rtl/amem_pkg.sv
// Package: shared phase encoding, timing record and timing-word decode for
// the asynchronous memory strobe sequencer.
// Assumes the timing word layout given in the brief (R2).
package amem_pkg;

    localparam int CNT_W = 6;   // wide enough for the largest field (strobe)

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_TURN   = 3'd1,
        PH_SETUP  = 3'd2,
        PH_STROBE = 3'd3,
        PH_HOLD   = 3'd4
    } phase_t;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] strobe;
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] turn;
    } timing_t;

    // Pick the phase counts that belong to one transfer direction.
    function automatic timing_t decode_timing(input logic [31:0] w, input logic is_write);
        timing_t t;
        if (is_write) begin
            t.setup  = CNT_W'(w[29:26]);
            t.strobe = CNT_W'(w[25:20]);
            t.hold   = CNT_W'(w[19:17]);
        end else begin
            t.setup  = CNT_W'(w[16:13]);
            t.strobe = CNT_W'(w[12:7]);
            t.hold   = CNT_W'(w[6:4]);
        end
        t.turn = CNT_W'(w[3:2]);
        return t;
    endfunction

endpackage

// File: rtl/amem_timing_latch.sv
// Timing latch: decodes the live timing word for the requested direction and
// holds a copy taken at acceptance, so later word changes do not disturb a
// running access.
// Assumes accept is high for one cycle per request.
module amem_timing_latch
    import amem_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] cfg_word,
    input  logic        req_write,
    input  logic        accept,
    output timing_t     cur,
    output timing_t     held
);

    // Live decode, used for the first phase loaded at acceptance.
    always_comb cur = decode_timing(cfg_word, req_write);

    // Snapshot of the counts for the remaining phases.
    always_ff @(posedge clk) begin
        if (!rst_n)      held <= '0;
        else if (accept) held <= cur;
    end

endmodule

// File: rtl/amem_phase_seq.sv
// Phase sequencer: walks idle -> (turnaround) -> setup -> strobe -> hold.
// Each phase lasts its count plus one cycle. A one-cycle done pulse follows
// the last hold cycle.
// Assumes accept is only raised while the phase is idle.
module amem_phase_seq
    import amem_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    accept,
    input  logic    acc_write,
    input  timing_t cur,
    input  timing_t held,
    output phase_t  phase,
    output logic    last_cycle,
    output logic    dir_write,
    output logic    done
);

    logic [CNT_W-1:0] cnt;
    logic             have_prev;
    logic             turn_needed;

    assign last_cycle  = (cnt == '0);
    assign turn_needed = have_prev && (dir_write != acc_write);

    // Phase state, countdown, direction history and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            have_prev <= 1'b0;
            dir_write <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= (phase == PH_HOLD) && last_cycle;
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        have_prev <= 1'b1;
                        dir_write <= acc_write;
                        if (turn_needed) begin
                            phase <= PH_TURN;
                            cnt   <= cur.turn;
                        end else begin
                            phase <= PH_SETUP;
                            cnt   <= cur.setup;
                        end
                    end
                end
                PH_TURN: begin
                    if (last_cycle) begin
                        phase <= PH_SETUP;
                        cnt   <= held.setup;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_SETUP: begin
                    if (last_cycle) begin
                        phase <= PH_STROBE;
                        cnt   <= held.strobe;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (last_cycle) begin
                        phase <= PH_HOLD;
                        cnt   <= held.hold;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (last_cycle) phase <= PH_IDLE;
                    else            cnt   <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/amem_ready_sync.sv
// Ready synchronizer: a STAGES-deep flop chain that brings the device
// ready/busy line into the clock domain.
// Assumes STAGES >= 1.
module amem_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single sampling flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_async;
            end
        end else begin : g_multi
            // Shift the line through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/amem_strobe_ctrl.sv
// Top: asynchronous memory strobe sequencer. Accepts single-byte requests,
// registers address/data/latch controls at acceptance and derives the device
// strobes from the sequencer phase.
// Assumes an 8-bit device; CLE_BIT/ALE_BIT select the latch address bits.
module amem_strobe_ctrl
    import amem_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int CLE_BIT     = 4,
    parameter int ALE_BIT     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_word,
    input  logic              nand_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              acc_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_cle,
    output logic              mem_ale,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din,
    input  logic              mem_rdy,
    output logic [7:0]        stat_o
);

    timing_t           t_cur, t_held;
    phase_t            phase;
    logic              last_cycle, dir_write, accept, in_window, rdy_sync;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              cle_q, ale_q;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    amem_timing_latch i_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_word  (cfg_word),
        .req_write (req_write),
        .accept    (accept),
        .cur       (t_cur),
        .held      (t_held)
    );

    amem_phase_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .acc_write  (req_write),
        .cur        (t_cur),
        .held       (t_held),
        .phase      (phase),
        .last_cycle (last_cycle),
        .dir_write  (dir_write),
        .done       (acc_done)
    );

    amem_ready_sync #(.STAGES(SYNC_STAGES)) i_rdy (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (mem_rdy),
        .q_sync  (rdy_sync)
    );

    // Capture address, write byte and latch selects when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            cle_q   <= 1'b0;
            ale_q   <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            cle_q   <= nand_mode && req_write && req_addr[CLE_BIT];
            ale_q   <= nand_mode && req_write && req_addr[ALE_BIT];
        end
    end

    // Sample device data on the final read strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if ((phase == PH_STROBE) && last_cycle && !dir_write)
            rd_data <= mem_din;
    end

    // Device pin decode from the current phase.
    always_comb begin
        in_window   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        mem_cs_n    = !in_window;
        mem_oe_n    = !((phase == PH_STROBE) && !dir_write);
        mem_we_n    = !((phase == PH_STROBE) && dir_write);
        mem_dout_en = in_window && dir_write;
        mem_cle     = in_window && cle_q;
        mem_ale     = in_window && ale_q;
        mem_addr    = addr_q;
        mem_dout    = wdata_q;
        stat_o      = {7'b0, rdy_sync};
    end

endmodule

// File: rtl/amem_strobe_checker.sv
// Checker: protocol properties of the strobe sequencer, bound to the top.
// Assumes synchronous active-low reset on rst_n.
module amem_strobe_checker (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic acc_done,
    input logic mem_cs_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_dout_en,
    input logic mem_cle,
    input logic mem_ale
);

    p_strobe_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

    p_setup_before_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_oe_n) || $fell(mem_we_n)) |-> $past(!mem_cs_n));

    p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_done);

    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> (req_ready && mem_cs_n));

    p_busy_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !req_ready);

    p_latch_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cle || mem_ale) |-> (mem_dout_en && !mem_cs_n));

endmodule

bind amem_strobe_ctrl amem_strobe_checker i_amem_strobe_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .acc_done    (acc_done),
    .mem_cs_n    (mem_cs_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_dout_en (mem_dout_en),
    .mem_cle     (mem_cle),
    .mem_ale     (mem_ale)
);

// File: tb/test_amem_strobe_ctrl.sv
// Bench: walks a vector table of accesses, then directed reset, synchronizer
// and interrupted-access cases.
module test_amem_strobe_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        nand_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, acc_done;
    logic [7:0]  rd_data;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_cle, mem_ale, mem_dout_en;
    logic [7:0]  mem_addr, mem_dout;
    logic [7:0]  mem_din = '0;
    logic        mem_rdy = 1'b0;
    logic [7:0]  stat_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    amem_strobe_ctrl i_amem_strobe_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .nand_mode(nand_mode),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .acc_done(acc_done),
        .rd_data(rd_data), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_cle(mem_cle), .mem_ale(mem_ale),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din), .mem_rdy(mem_rdy), .stat_o(stat_o)
    );

    typedef struct packed {
        logic       wr;
        logic       nand_on;
        logic [3:0] su;
        logic [5:0] st;
        logic [2:0] ho;
        logic [1:0] ta;
        logic [7:0] addr;
        logic [7:0] data;
        logic [3:0] gap;   // expected turnaround gap (R6)
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 4'd1,  6'd5,  3'd1, 2'd3, 8'h10, 8'hA5, 4'd0},
        '{1'b0, 1'b1, 4'd0,  6'd0,  3'd0, 2'd3, 8'h01, 8'h3C, 4'd0},
        '{1'b1, 1'b1, 4'd1,  6'd3,  3'd1, 2'd3, 8'h10, 8'h5A, 4'd4},
        '{1'b1, 1'b1, 4'd2,  6'd1,  3'd2, 2'd1, 8'h08, 8'h96, 4'd0},
        '{1'b0, 1'b0, 4'd15, 6'd63, 3'd7, 2'd2, 8'h00, 8'hC3, 4'd3},
        '{1'b1, 1'b0, 4'd0,  6'd0,  3'd0, 2'd0, 8'h18, 8'h81, 4'd1},
        '{1'b0, 1'b0, 4'd3,  6'd2,  3'd4, 2'd0, 8'h7E, 8'h42, 4'd1}
    };

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Timing word: fields of the other direction set to maximum, spare bits optional.
    function automatic logic [31:0] build_cfg(vec_t v, bit spare);
        logic [31:0] w = '0;
        w[3:2] = v.ta;
        if (v.wr) begin
            w[29:26] = v.su; w[25:20] = v.st; w[19:17] = v.ho;
            w[16:13] = 4'hF; w[12:7]  = 6'h3F; w[6:4]  = 3'h7;
        end else begin
            w[16:13] = v.su; w[12:7]  = v.st; w[6:4]  = v.ho;
            w[29:26] = 4'hF; w[25:20] = 6'h3F; w[19:17] = 3'h7;
        end
        if (spare) begin
            w[31:30] = 2'b11;
            w[1:0]   = 2'b11;
        end
        return w;
    endfunction

    task automatic run_access(vec_t v, bit spare);
        int gap = 0, cs = 0, strobe = 0, total = 0;
        int bad_latch = 0, bad_ready = 0, bad_other = 0, bad_bus = 0;
        logic exp_cle, exp_ale;
        exp_cle = v.nand_on && v.wr && v.addr[4];
        exp_ale = v.nand_on && v.wr && v.addr[3];
        @(negedge clk);
        chk("R5 ready before request", int'(req_ready), 1);
        cfg_word = build_cfg(v, spare);
        req_valid = 1'b1; req_write = v.wr; req_addr = v.addr;
        req_wdata = v.data; nand_mode = v.nand_on;
        @(negedge clk);
        req_valid = 1'b0;
        // R8: disturb every request input after acceptance.
        cfg_word = ~cfg_word; req_addr = ~v.addr; req_wdata = ~v.data;
        nand_mode = ~v.nand_on;
        while (!acc_done && total < 400) begin
            total++;
            if (mem_cs_n) gap++;
            else begin
                cs++;
                if (mem_cle !== exp_cle || mem_ale !== exp_ale) bad_latch++;
                if (req_ready) bad_ready++;
                if (mem_addr !== v.addr) bad_bus++;
                if (v.wr && (mem_dout_en !== 1'b1 || mem_dout !== v.data)) bad_bus++;
                if (!v.wr && mem_dout_en !== 1'b0) bad_bus++;
            end
            if (mem_cs_n && (mem_cle || mem_ale)) bad_latch++;
            if (v.wr ? !mem_we_n : !mem_oe_n) strobe++;
            if (v.wr ? !mem_oe_n : !mem_we_n) bad_other++;
            mem_din = mem_oe_n ? ~v.data : v.data;
            @(negedge clk);
        end
        chk("R6 turnaround gap", gap, int'(v.gap));
        chk("R2 chip-select window", cs, int'(v.su) + int'(v.st) + int'(v.ho) + 3);
        chk("R8 done latency", total, int'(v.gap) + int'(v.su) + int'(v.st) + int'(v.ho) + 3);
        chk(v.wr ? "R4 write strobe width" : "R3 read strobe width", strobe, int'(v.st) + 1);
        chk(v.wr ? "R4 other strobe idle" : "R3 other strobe idle", bad_other, 0);
        chk("R4 bus values in window", bad_bus, 0);
        chk("R7 latch lines", bad_latch, 0);
        chk("R5 not ready while busy", bad_ready, 0);
        if (!v.wr) chk("R3 read data", int'(rd_data), int'(v.data));
        @(negedge clk);
        chk("R5 done is one cycle", int'(acc_done), 0);
        chk("R5 ready after done", int'(req_ready), 1);
    endtask

    task automatic check_idle(string tag);
        chk({tag, " cs_n"}, int'(mem_cs_n), 1);
        chk({tag, " oe_n"}, int'(mem_oe_n), 1);
        chk({tag, " we_n"}, int'(mem_we_n), 1);
        chk({tag, " latch"}, int'({mem_cle, mem_ale, mem_dout_en}), 0);
        chk({tag, " done"}, int'(acc_done), 0);
        chk({tag, " ready"}, int'(req_ready), 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");

        // R9: ready synchronizer latency.
        mem_rdy = 1'b1;
        @(negedge clk);
        chk("R9 ready after one edge", int'(stat_o[0]), 0);
        @(negedge clk);
        chk("R9 ready after two edges", int'(stat_o[0]), 1);
        chk("R9 upper status bits", int'(stat_o[7:1]), 0);
        mem_rdy = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 busy after two edges", int'(stat_o[0]), 0);

        // Table walk (R2..R8).
        for (int i = 0; i < NVEC; i++) run_access(VECS[i], i[0]);

        // R1: reset cuts a long read short.
        @(negedge clk);
        cfg_word = build_cfg(VECS[4], 1'b0);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h20;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 access running", int'(mem_cs_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 reset mid-access");
        rst_n = 1'b1;

        // R6: first access after reset gets no gap, even in the other direction.
        run_access('{1'b1, 1'b1, 4'd1, 6'd2, 3'd1, 2'd3, 8'h18, 8'h77, 4'd0}, 1'b0);

        finish_run();
    end

endmodule